// File: doc/BRIEF.md
# SPI EEPROM Configuration Image Writer

This block saves a 16-bit word-addressed register and RAM space into an external serial EEPROM, so that the same image can be loaded back automatically after a later reset. It reads one word at a time through a simple memory read port with one cycle of latency. It splits each word into two bytes and sends them to the EEPROM over an SPI master in page-sized write bursts. Between bursts it polls the EEPROM status until the internal write has finished.

A copy only starts when the host writes a fixed key to the trigger input. At that moment the configuration word must also be in a safe state: armed, but with no controller or terminal started. If it is not, the request is refused and an error is latched, and the SPI pins do not move. A size select picks the capacity of the fitted EEPROM: a small part covers the lower part of the word space, and a large part covers all of it. The host follows progress on three flags: busy, done and error.

Top module: `eeprom_image_writer`

## Requirements
- R1: The SPI link runs with data launched on the leading SCK edge and captured on the trailing edge, most significant bit first. SCK idles low when CPOL is 0 (mode 1) and high when CPOL is 1 (mode 3).
- R2: A trigger write starts a copy only if its value equals TRIG_KEY and the block is idle. Any other value, or any write made while busy, changes neither busy, done nor err and produces no chip-select activity.
- R3: An otherwise valid trigger is refused when bit 13 (controller start) of the configuration word is 1. A refused trigger sets err, leaves busy low and starts no SPI traffic.
- R4: A trigger is refused in the same way when bit 4 or bit 5 (terminal start bits) of the configuration word is 1.
- R5: When the monitor-enable input is 1, a trigger is refused if bit 8 of the configuration word is 1. When that input is 0, bit 8 has no effect.
- R6: Each page is sent as follows: a lone write-enable byte 0x06, then chip select high, then a write byte 0x02, a 16-bit byte address (high byte first), and exactly PAGE_BYTES data bytes. No burst crosses a PAGE_BYTES boundary.
- R7: Word w is stored at EEPROM byte address 2w (its high byte) and 2w+1 (its low byte).
- R8: With size_big at 0 the copy covers words 0 to SMALL_WORDS-1. With size_big at 1 it covers words 0 to LARGE_WORDS-1. No word beyond that range is read, and no EEPROM byte beyond it is written.
- R9: After each page the block reads the status register (0x05 followed by status bytes) until bit 0 (write in progress) reads 0. Only then does it start the next page or finish.
- R10: Suppose POLL_MAX status bytes in a row show bit 0 set, or a status byte reads all ones. The copy then stops: err is set, busy drops, done stays low, and no further page is written.
- R11: After reset, busy, done and err are 0, chip select is high and SCK is idle. An accepted trigger sets busy and clears done and err. A completed copy drops busy and sets done. busy and done are never 1 together, and chip select stays high whenever busy is 0.
- R12: Every active SCK phase lasts exactly SCK_HALF system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_we | input | 1 | Host write strobe for the trigger register |
| trig_val | input | 16 | Value written to the trigger register |
| cfg_word | input | 16 | Current contents of the configuration register |
| mon_en_pin | input | 1 | Monitor-enable input pin |
| size_big | input | 1 | 0 selects the small EEPROM extent, 1 the large one |
| mem_rd | output | 1 | Word read strobe to the internal space |
| mem_addr | output | $clog2(LARGE_WORDS) | Word address of the read |
| mem_rdata | input | 16 | Read data, valid one cycle after mem_rd |
| spi_sck | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the EEPROM |
| spi_miso | input | 1 | SPI data from the EEPROM |
| busy | output | 1 | Copy in progress |
| done | output | 1 | Last copy completed |
| err | output | 1 | Last trigger refused or copy aborted |

## Verification
The assertions assume three things about the inputs. The memory port returns data exactly one cycle after each read strobe. cfg_word, mon_en_pin and size_big are steady during the cycle a trigger is sampled. trig_we is a single-cycle pulse. The bench keeps to these rules: it answers every read with a registered pattern word on the following clock, changes configuration inputs only on falling edges well before a trigger, and drives the trigger strobe for one cycle from a task. The EEPROM model plays a well-formed SPI slave. It returns status bytes that never read all ones, and it is told in advance how many busy polls each page will see. Both the normal polling path and the timeout path are therefore reached on purpose.

// File: rtl/eew_pkg.sv
package eew_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WREN,
      ST_GAP_A,
      ST_WCMD,
      ST_ADDR_H,
      ST_ADDR_L,
      ST_FETCH,
      ST_LATCH,
      ST_DHI,
      ST_DLO,
      ST_GAP_B,
      ST_PCMD,
      ST_PREAD,
      ST_GAP_C
   } seq_state_t;

   localparam logic [7:0] OP_WREN  = 8'h06;
   localparam logic [7:0] OP_WRITE = 8'h02;
   localparam logic [7:0] OP_RDSR  = 8'h05;
   localparam logic [7:0] OP_DUMMY = 8'h00;

   localparam int EE_AW = 16;

endpackage

// File: rtl/eew_spi_byte.sv
module eew_spi_byte #(
   parameter bit CPOL = 1'b0,
   parameter int HALF = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] tx,
   input  logic       miso,
   output logic       sck,
   output logic       mosi,
   output logic       busy,
   output logic       byte_done,
   output logic [7:0] rx
);

   localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;
   localparam logic [DW-1:0] DIV_END = DW'(HALF - 1);

   if (HALF < 1) begin : g_bad_half
      $error("eew_spi_byte: HALF must be at least 1");
   end

   logic [DW-1:0] div_q;
   logic [2:0]    bit_q;
   logic          lead_q;
   logic          act_q;
   logic          mosi_q;
   logic          done_q;
   logic [7:0]    tx_q;
   logic [7:0]    rx_q;
   logic          tick;

   assign tick = act_q && (div_q == DIV_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= '0;
         bit_q  <= '0;
         lead_q <= 1'b0;
         act_q  <= 1'b0;
         mosi_q <= 1'b0;
         done_q <= 1'b0;
         tx_q   <= '0;
         rx_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (!act_q) begin
            if (start) begin
               act_q  <= 1'b1;
               tx_q   <= tx;
               div_q  <= '0;
               bit_q  <= '0;
               lead_q <= 1'b0;
            end
         end else begin
            div_q <= tick ? '0 : div_q + 1'b1;
            if (tick) begin
               if (!lead_q) begin
                  // leading edge: launch next bit
                  lead_q <= 1'b1;
                  mosi_q <= tx_q[7];
                  tx_q   <= {tx_q[6:0], 1'b0};
               end else begin
                  // trailing edge: capture
                  lead_q <= 1'b0;
                  rx_q   <= {rx_q[6:0], miso};
                  bit_q  <= bit_q + 1'b1;
                  if (bit_q == 3'd7) begin
                     act_q  <= 1'b0;
                     done_q <= 1'b1;
                  end
               end
            end
         end
      end
   end

   if (CPOL) begin : g_idle_high
      assign sck = ~lead_q;
   end else begin : g_idle_low
      assign sck = lead_q;
   end

   assign mosi      = mosi_q;
   assign busy      = act_q;
   assign byte_done = done_q;
   assign rx        = rx_q;

   p_start_when_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !act_q);

   p_pulse_len_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lead_q) |=> (lead_q || HALF == 1));

endmodule

// File: rtl/eew_guard.sv
module eew_guard #(
   parameter int CFG_W     = 16,
   parameter int START_BIT = 13,
   parameter int T1_BIT    = 4,
   parameter int T2_BIT    = 5,
   parameter int MON_BIT   = 8
) (
   input  logic [CFG_W-1:0] cfg,
   input  logic             mon_pin,
   output logic             ok
);

   localparam logic [CFG_W-1:0] BLOCK_MASK =
      (CFG_W'(1) << START_BIT) | (CFG_W'(1) << T1_BIT) | (CFG_W'(1) << T2_BIT);
   localparam logic [CFG_W-1:0] MON_MASK = CFG_W'(1) << MON_BIT;

   if (START_BIT >= CFG_W || T1_BIT >= CFG_W || T2_BIT >= CFG_W || MON_BIT >= CFG_W)
   begin : g_bad_bits
      $error("eew_guard: interlock bit outside configuration word");
   end

   logic started;
   logic mon_clash;

   always_comb begin
      started   = |(cfg & BLOCK_MASK);
      mon_clash = mon_pin && (|(cfg & MON_MASK));
      ok        = !started && !mon_clash;
   end

endmodule

// File: rtl/eew_seq.sv
module eew_seq
   import eew_pkg::*;
#(
   parameter int          SMALL_WORDS = 1024,
   parameter int          LARGE_WORDS = 32768,
   parameter int          PAGE_BYTES  = 128,
   parameter int          GAP_CYC     = 4,
   parameter int          POLL_MAX    = 20000,
   parameter int          WIP_BIT     = 0,
   parameter logic [15:0] TRIG_KEY    = 16'h5EED
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           trig_we,
   input  logic [15:0]                    trig_val,
   input  logic                           guard_ok,
   input  logic                           size_big,
   output logic                           mem_rd,
   output logic [$clog2(LARGE_WORDS)-1:0] mem_addr,
   input  logic [15:0]                    mem_rdata,
   output logic                           spi_start,
   output logic [7:0]                     spi_tx,
   input  logic                           spi_busy,
   input  logic                           spi_done,
   input  logic [7:0]                     spi_rx,
   output logic                           cs_n,
   output logic                           busy,
   output logic                           done,
   output logic                           err
);

   localparam int MEM_AW = $clog2(LARGE_WORDS);
   localparam int CNT_W  = MEM_AW + 1;
   localparam int PB_W   = $clog2(PAGE_BYTES) + 1;
   localparam int GAP_W  = $clog2(GAP_CYC + 1);
   localparam int POLL_W = $clog2(POLL_MAX + 1);
   localparam logic [CNT_W-1:0]  SMALL_N = CNT_W'(SMALL_WORDS);
   localparam logic [CNT_W-1:0]  LARGE_N = CNT_W'(LARGE_WORDS);
   localparam logic [PB_W-1:0]   PAGE_N  = PB_W'(PAGE_BYTES);
   localparam logic [PB_W-1:0]   TWO     = PB_W'(2);
   localparam logic [GAP_W-1:0]  GAP_END = GAP_W'(GAP_CYC - 1);
   localparam logic [POLL_W-1:0] POLL_END = POLL_W'(POLL_MAX - 1);

   if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("eew_seq: PAGE_BYTES must be a power of two, at least 2");
   end
   if ((2 * SMALL_WORDS) % PAGE_BYTES != 0 || (2 * LARGE_WORDS) % PAGE_BYTES != 0)
   begin : g_bad_extent
      $error("eew_seq: extents must fill whole pages");
   end
   if (SMALL_WORDS > LARGE_WORDS || 2 * LARGE_WORDS > (1 << EE_AW)) begin : g_bad_size
      $error("eew_seq: extent does not fit the EEPROM byte address");
   end
   if (GAP_CYC < 1 || POLL_MAX < 1 || WIP_BIT > 7) begin : g_bad_misc
      $error("eew_seq: GAP_CYC and POLL_MAX must be positive, WIP_BIT below 8");
   end

   seq_state_t        state;
   logic              launched;
   logic [CNT_W-1:0]  word_addr;
   logic [CNT_W-1:0]  lim_q;
   logic [PB_W-1:0]   bcnt;
   logic [GAP_W-1:0]  gap_q;
   logic [POLL_W-1:0] poll_q;
   logic [15:0]       word_q;
   logic              busy_q;
   logic              done_q;
   logic              err_q;
   logic              sending;
   logic              key_hit;
   logic              dev_absent;
   logic [EE_AW-1:0]  byte_addr;

   assign key_hit    = trig_we && (trig_val == TRIG_KEY);
   assign dev_absent = &spi_rx;
   assign byte_addr  = EE_AW'({word_addr, 1'b0});
   assign sending    = state inside {ST_WREN, ST_WCMD, ST_ADDR_H, ST_ADDR_L,
                                     ST_DHI, ST_DLO, ST_PCMD, ST_PREAD};
   assign spi_start  = sending && !launched;
   assign cs_n       = state inside {ST_IDLE, ST_GAP_A, ST_GAP_B, ST_GAP_C};
   assign mem_rd     = (state == ST_FETCH);
   assign mem_addr   = word_addr[MEM_AW-1:0];
   assign busy       = busy_q;
   assign done       = done_q;
   assign err        = err_q;

   always_comb begin
      case (state)
         ST_WREN:   spi_tx = OP_WREN;
         ST_WCMD:   spi_tx = OP_WRITE;
         ST_ADDR_H: spi_tx = byte_addr[15:8];
         ST_ADDR_L: spi_tx = byte_addr[7:0];
         ST_DHI:    spi_tx = word_q[15:8];
         ST_DLO:    spi_tx = word_q[7:0];
         ST_PCMD:   spi_tx = OP_RDSR;
         default:   spi_tx = OP_DUMMY;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         launched  <= 1'b0;
         word_addr <= '0;
         lim_q     <= '0;
         bcnt      <= '0;
         gap_q     <= '0;
         poll_q    <= '0;
         word_q    <= '0;
         busy_q    <= 1'b0;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         if (spi_start)     launched <= 1'b1;
         else if (spi_done) launched <= 1'b0;

         case (state)
            ST_IDLE: begin
               if (key_hit) begin
                  done_q <= 1'b0;
                  if (guard_ok) begin
                     busy_q    <= 1'b1;
                     err_q     <= 1'b0;
                     word_addr <= '0;
                     lim_q     <= size_big ? LARGE_N : SMALL_N;
                     state     <= ST_WREN;
                  end else begin
                     err_q <= 1'b1;
                  end
               end
            end
            ST_WREN: if (spi_done) begin
               gap_q <= '0;
               state <= ST_GAP_A;
            end
            ST_GAP_A: begin
               if (gap_q == GAP_END) state <= ST_WCMD;
               else                  gap_q <= gap_q + 1'b1;
            end
            ST_WCMD:   if (spi_done) state <= ST_ADDR_H;
            ST_ADDR_H: if (spi_done) state <= ST_ADDR_L;
            ST_ADDR_L: if (spi_done) begin
               bcnt  <= '0;
               state <= ST_FETCH;
            end
            ST_FETCH: state <= ST_LATCH;
            ST_LATCH: begin
               word_q <= mem_rdata;
               state  <= ST_DHI;
            end
            ST_DHI: if (spi_done) state <= ST_DLO;
            ST_DLO: if (spi_done) begin
               word_addr <= word_addr + 1'b1;
               bcnt      <= bcnt + TWO;
               if (bcnt + TWO == PAGE_N) begin
                  gap_q <= '0;
                  state <= ST_GAP_B;
               end else begin
                  state <= ST_FETCH;
               end
            end
            ST_GAP_B: begin
               if (gap_q == GAP_END) begin
                  poll_q <= '0;
                  state  <= ST_PCMD;
               end else begin
                  gap_q <= gap_q + 1'b1;
               end
            end
            ST_PCMD: if (spi_done) state <= ST_PREAD;
            ST_PREAD: if (spi_done) begin
               if (dev_absent) begin
                  err_q  <= 1'b1;
                  busy_q <= 1'b0;
                  state  <= ST_IDLE;
               end else if (!spi_rx[WIP_BIT]) begin
                  gap_q <= '0;
                  state <= ST_GAP_C;
               end else if (poll_q == POLL_END) begin
                  err_q  <= 1'b1;
                  busy_q <= 1'b0;
                  state  <= ST_IDLE;
               end else begin
                  poll_q <= poll_q + 1'b1;
               end
            end
            ST_GAP_C: begin
               if (gap_q != GAP_END) begin
                  gap_q <= gap_q + 1'b1;
               end else if (word_addr == lim_q) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end else begin
                  state <= ST_WREN;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   p_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && trig_we && trig_val != TRIG_KEY) |=>
         (state == ST_IDLE && $stable(err_q) && $stable(done_q)));

   p_refuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && key_hit && !guard_ok) |=> (err_q && !busy_q && cs_n));

   p_cs_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !spi_busy);

   p_page_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DLO && spi_done) |-> (bcnt + TWO <= PAGE_N));

   p_rd_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> (word_addr < lim_q));

   p_wait_wip_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PREAD && spi_done && spi_rx[WIP_BIT]) |=>
         (state == ST_PREAD || state == ST_IDLE));

   p_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_q && done_q));

   p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> cs_n);

endmodule

// File: rtl/eeprom_image_writer.sv
module eeprom_image_writer #(
   parameter bit          CPOL        = 1'b0,
   parameter int          SCK_HALF    = 3,
   parameter int          SMALL_WORDS = 1024,
   parameter int          LARGE_WORDS = 32768,
   parameter int          PAGE_BYTES  = 128,
   parameter int          GAP_CYC     = 4,
   parameter int          POLL_MAX    = 20000,
   parameter logic [15:0] TRIG_KEY    = 16'h5EED,
   parameter int          START_BIT   = 13,
   parameter int          T1_BIT      = 4,
   parameter int          T2_BIT      = 5,
   parameter int          MON_BIT     = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           trig_we,
   input  logic [15:0]                    trig_val,
   input  logic [15:0]                    cfg_word,
   input  logic                           mon_en_pin,
   input  logic                           size_big,
   output logic                           mem_rd,
   output logic [$clog2(LARGE_WORDS)-1:0] mem_addr,
   input  logic [15:0]                    mem_rdata,
   output logic                           spi_sck,
   output logic                           spi_cs_n,
   output logic                           spi_mosi,
   input  logic                           spi_miso,
   output logic                           busy,
   output logic                           done,
   output logic                           err
);

   logic       guard_ok;
   logic       spi_start;
   logic [7:0] spi_tx;
   logic       spi_busy;
   logic       spi_done;
   logic [7:0] spi_rx;

   eew_guard #(
      .CFG_W     (16),
      .START_BIT (START_BIT),
      .T1_BIT    (T1_BIT),
      .T2_BIT    (T2_BIT),
      .MON_BIT   (MON_BIT)
   ) u_guard (
      .cfg     (cfg_word),
      .mon_pin (mon_en_pin),
      .ok      (guard_ok)
   );

   eew_seq #(
      .SMALL_WORDS (SMALL_WORDS),
      .LARGE_WORDS (LARGE_WORDS),
      .PAGE_BYTES  (PAGE_BYTES),
      .GAP_CYC     (GAP_CYC),
      .POLL_MAX    (POLL_MAX),
      .WIP_BIT     (0),
      .TRIG_KEY    (TRIG_KEY)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig_we   (trig_we),
      .trig_val  (trig_val),
      .guard_ok  (guard_ok),
      .size_big  (size_big),
      .mem_rd    (mem_rd),
      .mem_addr  (mem_addr),
      .mem_rdata (mem_rdata),
      .spi_start (spi_start),
      .spi_tx    (spi_tx),
      .spi_busy  (spi_busy),
      .spi_done  (spi_done),
      .spi_rx    (spi_rx),
      .cs_n      (spi_cs_n),
      .busy      (busy),
      .done      (done),
      .err       (err)
   );

   eew_spi_byte #(
      .CPOL (CPOL),
      .HALF (SCK_HALF)
   ) u_spi (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (spi_start),
      .tx        (spi_tx),
      .miso      (spi_miso),
      .sck       (spi_sck),
      .mosi      (spi_mosi),
      .busy      (spi_busy),
      .byte_done (spi_done),
      .rx        (spi_rx)
   );

endmodule

// File: tb/test_eeprom_image_writer.sv
module test_eeprom_image_writer;

   localparam int          CLK_PERIOD = 10;
   localparam int          SMALL      = 32;
   localparam int          LARGE      = 96;
   localparam int          PAGE       = 16;
   localparam int          HALF       = 2;
   localparam int          PMAX       = 12;
   localparam int          EE_BYTES   = 256;
   localparam logic [15:0] KEY        = 16'h5EED;
   localparam logic [15:0] CFG_GOOD   = 16'h1040;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trig_we = 1'b0;
   logic [15:0] trig_val = '0;
   logic [15:0] cfg_word = CFG_GOOD;
   logic        mon_en_pin = 1'b0;
   logic        size_big = 1'b0;
   logic        mem_rd;
   logic [6:0]  mem_addr;
   logic [15:0] mem_rdata = '0;
   logic        spi_sck, spi_cs_n, spi_mosi;
   logic        spi_miso = 1'b0;
   logic        busy, done, err;

   int vec = 0;
   int miss = 0;
   int cur_words = SMALL;
   bit run_mon = 1'b0;
   int hi_run = 0;

   // EEPROM model state
   logic [7:0] ee [EE_BYTES];
   logic [7:0] rxq [$];
   logic [7:0] cur = '0;
   logic [7:0] out_byte = '0;
   int bitc = 0;
   bit wel = 1'b0;
   int wip_left = 0;
   int wip_cfg = 3;
   int pages = 0;
   int page_err = 0;
   int wel_err = 0;
   int early_err = 0;
   int polls = 0;
   int cs_falls = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   eeprom_image_writer #(
      .CPOL (1'b0), .SCK_HALF (HALF), .SMALL_WORDS (SMALL), .LARGE_WORDS (LARGE),
      .PAGE_BYTES (PAGE), .GAP_CYC (2), .POLL_MAX (PMAX), .TRIG_KEY (KEY)
   ) i_eeprom_image_writer (
      .clk (clk), .rst_n (rst_n), .trig_we (trig_we), .trig_val (trig_val),
      .cfg_word (cfg_word), .mon_en_pin (mon_en_pin), .size_big (size_big),
      .mem_rd (mem_rd), .mem_addr (mem_addr), .mem_rdata (mem_rdata),
      .spi_sck (spi_sck), .spi_cs_n (spi_cs_n), .spi_mosi (spi_mosi),
      .spi_miso (spi_miso), .busy (busy), .done (done), .err (err)
   );

   function automatic logic [15:0] pat(input int a);
      return 16'((a * 40503) ^ 23130);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vec++;
      if (act !== exp) begin
         miss++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // memory with one cycle of read latency
   always @(posedge clk) if (mem_rd) mem_rdata <= pat(int'(mem_addr));

   // SPI EEPROM model, mode 1: launch on rising, capture on falling
   always @(negedge spi_cs_n) begin
      bitc = 0; cur = '0; out_byte = '0; cs_falls++;
   end

   always @(negedge spi_sck) if (spi_cs_n == 1'b0) begin
      cur = {cur[6:0], spi_mosi};
      bitc++;
      if (bitc == 8) begin
         bitc = 0;
         rxq.push_back(cur);
         if (rxq[0] == 8'h05) begin
            if (rxq.size() >= 2) begin
               polls++;
               if (wip_left > 0) wip_left--;
            end
            out_byte = {7'b0, wip_left > 0};
         end else begin
            out_byte = '0;
         end
      end
   end

   always @(posedge spi_sck) if (spi_cs_n == 1'b0) spi_miso = out_byte[3'(7 - bitc)];

   always @(posedge spi_cs_n) begin
      if (rxq.size() == 1 && rxq[0] == 8'h06) begin
         wel = 1'b1;
      end else if (rxq.size() >= 3 && rxq[0] == 8'h02) begin
         int a;
         int n;
         a = int'({rxq[1], rxq[2]});
         n = rxq.size() - 3;
         if (!wel) wel_err++;
         if (wip_left > 0) early_err++;
         if (n != PAGE || (a % PAGE) + n > PAGE) page_err++;
         for (int i = 0; i < n; i++) if (a + i < EE_BYTES) ee[a + i] = rxq[3 + i];
         wel = 1'b0;
         wip_left = wip_cfg;
         pages++;
      end
      rxq.delete();
   end

   // per-clock comparison against the behavioural expectations
   always @(negedge clk) if (run_mon) begin
      if (!busy) begin
         chk("R11 idle cs_n", {31'b0, spi_cs_n}, 32'd1);
         chk("R1 idle sck",   {31'b0, spi_sck},  32'd0);
      end
      chk("R11 busy&done", {31'b0, busy & done}, 32'd0);
      if (mem_rd) begin
         chk("R2 rd only busy", {31'b0, busy}, 32'd1);
         chk("R8 rd range", {31'b0, int'(mem_addr) < cur_words}, 32'd1);
      end
      if (spi_sck) hi_run++;
      else begin
         if (hi_run != 0) chk("R12 sck phase", hi_run, HALF);
         hi_run = 0;
      end
   end

   task automatic trig(input logic [15:0] v);
      @(negedge clk);
      trig_we = 1'b1; trig_val = v;
      @(negedge clk);
      trig_we = 1'b0; trig_val = '0;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 60000) begin @(negedge clk); n++; end
      @(negedge clk);
   endtask

   task automatic ee_clear();
      for (int i = 0; i < EE_BYTES; i++) ee[i] = 8'hFF;
      pages = 0; page_err = 0; wel_err = 0; early_err = 0; polls = 0;
   endtask

   task automatic ee_verify(input int words, input string req);
      int bad = 0;
      for (int i = 0; i < EE_BYTES; i++) begin
         logic [15:0] w;
         logic [7:0]  e;
         w = pat(i / 2);
         e = (i < 2 * words) ? ((i % 2 == 0) ? w[15:8] : w[7:0]) : 8'hFF;
         if (ee[i] !== e) begin
            bad++;
            if (bad < 4) $display("FAIL %s byte %0d actual=%0h expected=%0h", req, i, ee[i], e);
         end
      end
      chk(req, bad, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      miss++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vec, miss);
      $finish;
   end

   initial begin
      ee_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 reset busy", {31'b0, busy}, 0);
      chk("R11 reset done", {31'b0, done}, 0);
      chk("R11 reset err",  {31'b0, err},  0);
      chk("R11 reset cs_n", {31'b0, spi_cs_n}, 1);
      chk("R1 reset sck",   {31'b0, spi_sck},  0);
      run_mon = 1'b1;

      // R3 controller start bit set
      cfg_word = CFG_GOOD | 16'h2000;
      trig(KEY);
      chk("R3 refused err", {31'b0, err}, 1);
      chk("R3 refused busy", {31'b0, busy}, 0);
      // R4 terminal start bits
      cfg_word = CFG_GOOD | 16'h0010;
      trig(KEY);
      chk("R4 bit4 err", {31'b0, err}, 1);
      chk("R4 bit4 busy", {31'b0, busy}, 0);
      cfg_word = CFG_GOOD | 16'h0020;
      trig(KEY);
      chk("R4 bit5 busy", {31'b0, busy}, 0);
      // R5 monitor clash
      mon_en_pin = 1'b1;
      cfg_word = CFG_GOOD | 16'h0100;
      trig(KEY);
      chk("R5 clash err", {31'b0, err}, 1);
      chk("R5 clash busy", {31'b0, busy}, 0);
      // R2 wrong key ignored with a safe configuration
      mon_en_pin = 1'b0;
      cfg_word = CFG_GOOD;
      trig(16'h5EEC);
      repeat (50) @(negedge clk);
      chk("R2 wrong key busy", {31'b0, busy}, 0);
      chk("R2 wrong key err kept", {31'b0, err}, 1);
      chk("R3 R4 R5 no cs activity", cs_falls, 0);
      chk("R3 no pages", pages, 0);

      // small run, bit 8 set but monitor pin low (R5)
      cfg_word = CFG_GOOD | 16'h0100;
      size_big = 1'b0; cur_words = SMALL; wip_cfg = 3;
      trig(KEY);
      chk("R11 start busy", {31'b0, busy}, 1);
      chk("R11 start err cleared", {31'b0, err}, 0);
      repeat (60) @(negedge clk);
      trig(KEY); // R2 ignored while busy
      wait_idle();
      chk("R11 small done", {31'b0, done}, 1);
      chk("R11 small err", {31'b0, err}, 0);
      ee_verify(SMALL, "R7 R8 R1 small image");
      chk("R6 small pages", pages, 2 * SMALL / PAGE);
      chk("R2 busy trigger ignored", pages, 2 * SMALL / PAGE);
      chk("R6 page form", page_err, 0);
      chk("R6 write enable", wel_err, 0);
      chk("R9 write during wip", early_err, 0);
      chk("R9 polls", polls, (2 * SMALL / PAGE) * (wip_cfg + 1));

      // large run, monitor pin high with bit 8 clear
      ee_clear();
      mon_en_pin = 1'b1; cfg_word = CFG_GOOD;
      size_big = 1'b1; cur_words = LARGE; wip_cfg = 1;
      trig(KEY);
      chk("R11 done cleared", {31'b0, done}, 0);
      chk("R5 pin high proceeds", {31'b0, busy}, 1);
      wait_idle();
      chk("R11 large done", {31'b0, done}, 1);
      ee_verify(LARGE, "R7 R8 large image");
      chk("R6 large pages", pages, 2 * LARGE / PAGE);
      chk("R6 large form", page_err, 0);
      chk("R9 large early", early_err, 0);

      // poll timeout
      ee_clear();
      size_big = 1'b0; cur_words = SMALL; wip_cfg = 1000;
      trig(KEY);
      wait_idle();
      chk("R10 timeout err", {31'b0, err}, 1);
      chk("R10 timeout done", {31'b0, done}, 0);
      chk("R10 timeout busy", {31'b0, busy}, 0);
      chk("R10 single page", pages, 1);
      chk("R10 poll count", polls, PMAX);
      wip_left = 0;
      repeat (20) @(negedge clk);

      run_mon = 1'b0;
      $display("  == %0d vectors applied, %0d miscompares ==", vec, miss);
      $finish;
   end

endmodule